// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides, for a small 32-bit CPU core, whether a pending exception or a hardware interrupt request is taken when the core asks for an evaluation. It performs the context save and the status-register changes for the taken event, records the event code, and produces the handler entry address. The pipeline raises `eval` for one cycle and presents the current status word, program counter, stack register, vector base, delay-slot flag and halted-waiting flag. It also presents the vector answer of an external priority controller, which receives the current interrupt mask level from this block.

The decision is combinational in the evaluation cycle. All results are registered, so they appear one cycle later together with a one-cycle `taken` strobe. The control is a two-state machine. `ST_IDLE` means no entry was made in the previous cycle. `ST_ENTRY` means an entry was just registered and `taken` is high. The transition IDLE→ENTRY, or ENTRY→ENTRY, fires when an evaluation produces an entry. The transition ENTRY→IDLE, or IDLE→IDLE, fires otherwise.

Status word bit positions used throughout: block bit 28, register-bank bit 29, privileged-mode bit 30, FPU-disable bit 15, interrupt mask level bits 7:4. An exception code of all ones (0xFFF) means no exception is pending.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception (code ≠ 0xFFF) and an interrupt request are both present in an evaluation, the exception is taken: EXPEVT receives the code and INTEVT keeps its value.
- R2: With status bit 28 set, any exception code other than 0x1E0 is taken as code 0x000. Code 0x1E0 is taken unchanged.
- R3: With status bit 28 set, an interrupt is not taken unless `halt_wait` is high. Any entry made with bit 28 set pulses `halt_clr` together with `taken`.
- R4: `irq_mask_lvl` always equals status bits 7:4. An interrupt whose `vec_valid` is low causes no entry and changes no output.
- R5: On entry, SSR gets the status word, SGR gets R15, and the new status word is the old one with bits 28, 29 and 30 set.
- R6: When `dslot` is high on entry, SPC is the PC minus 2 and `dslot_clr` pulses with `taken`. Otherwise SPC is the PC, apart from the R8 trap adjustment.
- R7: Effective codes 0x000, 0x020 and 0x140 clear status bit 15, set bits 7:4 to 0xF and load PC with 0xA0000000.
- R8: Codes 0x040 and 0x060 load PC with VBR+0x400. Every other exception loads VBR+0x100. Code 0x160 adds 2 to the saved PC.
- R9: A taken interrupt writes the vector to INTEVT, loads PC with VBR+0x600, and leaves EXPEVT unchanged.
- R10: `taken` is high for exactly the cycle after an evaluation that produced an entry. Without an entry, all registered outputs hold their values.
- R11: After reset, all registered outputs and strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval | input | 1 | Evaluate pending events this cycle |
| exc_code | input | 12 | Pending exception code, 0xFFF for none |
| irq_req | input | 1 | Hardware interrupt request |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| r15_in | input | 32 | Current stack register |
| vbr_in | input | 32 | Vector base |
| dslot | input | 1 | Event occurs in a delay slot |
| halt_wait | input | 1 | Core halted waiting for an interrupt |
| vec_valid | input | 1 | Priority controller returned a vector |
| irq_vec | input | 12 | Interrupt vector from the controller |
| irq_mask_lvl | output | 4 | Mask level sent to the controller |
| sr_out | output | 32 | Updated status word |
| ssr | output | 32 | Saved status word |
| spc | output | 32 | Saved program counter |
| sgr | output | 32 | Saved stack register |
| expevt | output | 12 | Exception event code |
| intevt | output | 12 | Interrupt event code |
| pc_out | output | 32 | Handler entry address |
| taken | output | 1 | Entry strobe |
| dslot_clr | output | 1 | Clear the delay-slot flags |
| halt_clr | output | 1 | Clear the halted-waiting flag |

## Verification
Two functions can fall in the same cycle. One is arbitration between a pending exception and an interrupt request, which can coincide with the blocked-state rewrite of the exception code. The other is the delay-slot rewind, which can coincide with the trap adjustment of the saved PC. The bench provokes both by presenting an exception together with an interrupt request while status bit 28 is set, and a trap code inside a delay slot. It judges them through EXPEVT, INTEVT, SPC and PC against a behavioural model that is compared on every clock.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int SR_BLOCK = 28;
    localparam int SR_BANK  = 29;
    localparam int SR_PRIV  = 30;
    localparam int SR_FPUOFF = 15;
    localparam int SR_MASK_LO = 4;
    localparam int SR_MASK_W  = 4;

    localparam int CODE_RESET   = 'h000;
    localparam int CODE_MRESET  = 'h020;
    localparam int CODE_MULTI   = 'h140;
    localparam int CODE_MISS_RD = 'h040;
    localparam int CODE_MISS_WR = 'h060;
    localparam int CODE_TRAP    = 'h160;
    localparam int CODE_KEEP    = 'h1E0;

    localparam logic [31:0] RESET_VECTOR = 32'hA000_0000;
    localparam int OFS_GENERAL = 'h100;
    localparam int OFS_MISS    = 'h400;
    localparam int OFS_IRQ     = 'h600;

    typedef enum logic [0:0] {ST_IDLE, ST_ENTRY} seq_state_t;
endpackage

// File: rtl/exc_decide.sv
module exc_decide
    import exc_entry_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              eval,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              blocked,
    input  logic              halt_wait,
    input  logic              vec_valid,
    output logic              take,
    output logic              take_exc,
    output logic [CODE_W-1:0] code_eff
);
    localparam logic [CODE_W-1:0] NONE = {CODE_W{1'b1}};

    logic exc_pend;
    logic irq_ok;

    always_comb begin
        exc_pend = eval && (exc_code != NONE);
        irq_ok   = eval && !exc_pend && irq_req && vec_valid
                   && (!blocked || halt_wait);
        if (blocked && exc_code != CODE_W'(CODE_KEEP))
            code_eff = CODE_W'(CODE_RESET);
        else
            code_eff = exc_code;
        take_exc = exc_pend;
        take     = exc_pend || irq_ok;
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input  logic              take_exc,
    input  logic [CODE_W-1:0] code_eff,
    input  logic [XLEN-1:0]   sr,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   vbr,
    input  logic              dslot,
    output logic [XLEN-1:0]   sr_new,
    output logic [XLEN-1:0]   spc_new,
    output logic [XLEN-1:0]   pc_new
);
    logic is_rst, is_miss, is_trap;
    logic [XLEN-1:0] rewind, bump;

    always_comb begin
        is_rst  = take_exc && (code_eff == CODE_W'(CODE_RESET)
                  || code_eff == CODE_W'(CODE_MRESET)
                  || code_eff == CODE_W'(CODE_MULTI));
        is_miss = take_exc && (code_eff == CODE_W'(CODE_MISS_RD)
                  || code_eff == CODE_W'(CODE_MISS_WR));
        is_trap = take_exc && (code_eff == CODE_W'(CODE_TRAP));

        sr_new = sr;
        sr_new[SR_BLOCK] = 1'b1;
        sr_new[SR_BANK]  = 1'b1;
        sr_new[SR_PRIV]  = 1'b1;
        if (is_rst) begin
            sr_new[SR_FPUOFF] = 1'b0;
            sr_new[SR_MASK_LO +: SR_MASK_W] = '1;
        end

        rewind  = dslot   ? XLEN'(2) : '0;
        bump    = is_trap ? XLEN'(2) : '0;
        spc_new = pc - rewind + bump;

        if (!take_exc)
            pc_new = vbr + XLEN'(OFS_IRQ);
        else if (is_rst)
            pc_new = XLEN'(RESET_VECTOR);
        else if (is_miss)
            pc_new = vbr + XLEN'(OFS_MISS);
        else
            pc_new = vbr + XLEN'(OFS_GENERAL);
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   r15_in,
    input  logic [XLEN-1:0]   vbr_in,
    input  logic              dslot,
    input  logic              halt_wait,
    input  logic              vec_valid,
    input  logic [CODE_W-1:0] irq_vec,
    output logic [3:0]        irq_mask_lvl,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   spc,
    output logic [XLEN-1:0]   sgr,
    output logic [CODE_W-1:0] expevt,
    output logic [CODE_W-1:0] intevt,
    output logic [XLEN-1:0]   pc_out,
    output logic              taken,
    output logic              dslot_clr,
    output logic              halt_clr
);
    seq_state_t state_q, state_d;

    logic              take, take_exc;
    logic [CODE_W-1:0] code_eff;
    logic [XLEN-1:0]   sr_new, spc_new, pc_new;

    assign irq_mask_lvl = sr_in[SR_MASK_LO +: SR_MASK_W];

    exc_decide #(.CODE_W(CODE_W)) decide_i (
        .eval      (eval),
        .exc_code  (exc_code),
        .irq_req   (irq_req),
        .blocked   (sr_in[SR_BLOCK]),
        .halt_wait (halt_wait),
        .vec_valid (vec_valid),
        .take      (take),
        .take_exc  (take_exc),
        .code_eff  (code_eff)
    );

    exc_target #(.XLEN(XLEN), .CODE_W(CODE_W)) target_i (
        .take_exc (take_exc),
        .code_eff (code_eff),
        .sr       (sr_in),
        .pc       (pc_in),
        .vbr      (vbr_in),
        .dslot    (dslot),
        .sr_new   (sr_new),
        .spc_new  (spc_new),
        .pc_new   (pc_new)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = take ? ST_ENTRY : ST_IDLE;
            ST_ENTRY: state_d = take ? ST_ENTRY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign taken = (state_q == ST_ENTRY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_out    <= '0;
            ssr       <= '0;
            spc       <= '0;
            sgr       <= '0;
            expevt    <= '0;
            intevt    <= '0;
            pc_out    <= '0;
            dslot_clr <= 1'b0;
            halt_clr  <= 1'b0;
        end else begin
            dslot_clr <= take && dslot;
            halt_clr  <= take && sr_in[SR_BLOCK];
            if (take) begin
                ssr    <= sr_in;
                sgr    <= r15_in;
                sr_out <= sr_new;
                spc    <= spc_new;
                pc_out <= pc_new;
                if (take_exc) expevt <= code_eff;
                else          intevt <= irq_vec;
            end
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eval,
    input logic [CODE_W-1:0] exc_code,
    input logic              irq_req,
    input logic [XLEN-1:0]   sr_in,
    input logic [XLEN-1:0]   r15_in,
    input logic              halt_wait,
    input logic              vec_valid,
    input logic [XLEN-1:0]   sr_out,
    input logic [XLEN-1:0]   ssr,
    input logic [XLEN-1:0]   sgr,
    input logic [CODE_W-1:0] expevt,
    input logic [CODE_W-1:0] intevt,
    input logic [XLEN-1:0]   pc_out,
    input logic              taken
);
    localparam logic [CODE_W-1:0] NONE = {CODE_W{1'b1}};

    a_r1_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && exc_code != NONE && irq_req) |=> (taken && $stable(intevt)));

    a_r2_block_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && exc_code != NONE && exc_code != CODE_W'('h1E0) && sr_in[28])
        |=> (expevt == '0 && pc_out == 32'hA000_0000));

    a_r3_block_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && exc_code == NONE && sr_in[28] && !halt_wait) |=> !taken);

    a_r4_no_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && exc_code == NONE && !vec_valid) |=> !taken);

    a_r5_sr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (sr_out[30:28] == 3'b111));

    a_r5_saved: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (ssr == $past(sr_in) && sgr == $past(r15_in)));

    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> !taken);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> ($stable(pc_out) && $stable(expevt)));
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .eval(eval), .exc_code(exc_code),
    .irq_req(irq_req), .sr_in(sr_in), .r15_in(r15_in),
    .halt_wait(halt_wait), .vec_valid(vec_valid), .sr_out(sr_out),
    .ssr(ssr), .sgr(sgr), .expevt(expevt), .intevt(intevt),
    .pc_out(pc_out), .taken(taken)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval = 1'b0;
    logic [11:0] exc_code = 12'hFFF;
    logic        irq_req = 1'b0;
    logic [31:0] sr_in = '0, pc_in = '0, r15_in = '0, vbr_in = '0;
    logic        dslot = 1'b0, halt_wait = 1'b0, vec_valid = 1'b0;
    logic [11:0] irq_vec = '0;
    logic [3:0]  irq_mask_lvl;
    logic [31:0] sr_out, ssr, spc, sgr, pc_out;
    logic [11:0] expevt, intevt;
    logic        taken, dslot_clr, halt_clr;

    always #10 clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .eval(eval), .exc_code(exc_code),
        .irq_req(irq_req), .sr_in(sr_in), .pc_in(pc_in), .r15_in(r15_in),
        .vbr_in(vbr_in), .dslot(dslot), .halt_wait(halt_wait),
        .vec_valid(vec_valid), .irq_vec(irq_vec), .irq_mask_lvl(irq_mask_lvl),
        .sr_out(sr_out), .ssr(ssr), .spc(spc), .sgr(sgr), .expevt(expevt),
        .intevt(intevt), .pc_out(pc_out), .taken(taken),
        .dslot_clr(dslot_clr), .halt_clr(halt_clr)
    );

    int checks = 0;
    int failures = 0;
    string req_now = "R11";
    string req_exp = "R11";
    bit started = 0;

    logic [31:0] m_sr, m_ssr, m_spc, m_sgr, m_pc;
    logic [11:0] m_exp, m_int;
    logic        m_taken, m_dsc, m_hc;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference, evaluated at each rising edge
    always @(posedge clk) begin
        logic [11:0] code;
        bit is_exc, blk, go_irq;
        started = 1;
        req_exp = req_now;
        if (!rst_n) begin
            m_sr = 0; m_ssr = 0; m_spc = 0; m_sgr = 0; m_pc = 0;
            m_exp = 0; m_int = 0; m_taken = 0; m_dsc = 0; m_hc = 0;
        end else begin
            m_taken = 0; m_dsc = 0; m_hc = 0;
            if (eval) begin
                is_exc = (exc_code != 12'hFFF);
                blk    = sr_in[28];
                code   = exc_code;
                if (is_exc && blk && code != 12'h1E0) code = 12'h000;
                go_irq = !is_exc && irq_req && vec_valid && (!blk || halt_wait);
                if (is_exc || go_irq) begin
                    m_taken = 1; m_dsc = dslot; m_hc = blk;
                    m_ssr = sr_in; m_sgr = r15_in;
                    m_sr = sr_in | 32'h7000_0000;
                    m_spc = dslot ? pc_in - 2 : pc_in;
                    if (go_irq) begin
                        m_int = irq_vec;
                        m_pc = vbr_in + 32'h600;
                    end else begin
                        m_exp = code;
                        case (code)
                            12'h000, 12'h020, 12'h140: begin
                                m_sr[15] = 1'b0;
                                m_sr[7:4] = 4'hF;
                                m_pc = 32'hA000_0000;
                            end
                            12'h040, 12'h060: m_pc = vbr_in + 32'h400;
                            12'h160: begin
                                m_spc = m_spc + 2;
                                m_pc = vbr_in + 32'h100;
                            end
                            default: m_pc = vbr_in + 32'h100;
                        endcase
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            check(req_exp, "taken",     {31'b0, taken},     {31'b0, m_taken});
            check(req_exp, "dslot_clr", {31'b0, dslot_clr}, {31'b0, m_dsc});
            check(req_exp, "halt_clr",  {31'b0, halt_clr},  {31'b0, m_hc});
            check(req_exp, "sr_out", sr_out, m_sr);
            check(req_exp, "ssr", ssr, m_ssr);
            check(req_exp, "spc", spc, m_spc);
            check(req_exp, "sgr", sgr, m_sgr);
            check(req_exp, "pc_out", pc_out, m_pc);
            check(req_exp, "expevt", {20'b0, expevt}, {20'b0, m_exp});
            check(req_exp, "intevt", {20'b0, intevt}, {20'b0, m_int});
            check("R4", "irq_mask_lvl", {28'b0, irq_mask_lvl}, {28'b0, sr_in[7:4]});
        end
    end

    task automatic fire(string req, logic [11:0] code, bit irq, logic [31:0] sr,
                        logic [31:0] pc, bit ds, bit hw, bit vv, logic [11:0] vec);
        @(negedge clk);
        req_now = req;
        eval = 1; exc_code = code; irq_req = irq; sr_in = sr; pc_in = pc;
        r15_in = pc ^ 32'h5A5A_0000; dslot = ds; halt_wait = hw;
        vec_valid = vv; irq_vec = vec;
        @(negedge clk);
        eval = 0; exc_code = 12'hFFF; irq_req = 0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        vbr_in = 32'h8C00_0000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8 general, miss and trap offsets; R5 context save
        fire("R8",  12'h0E0, 0, 32'h0000_00F0, 32'h1000_0100, 0, 0, 0, 0);
        fire("R8",  12'h040, 0, 32'h0000_0030, 32'h1000_0200, 0, 0, 0, 0);
        fire("R8",  12'h060, 0, 32'h0000_8010, 32'h1000_0300, 0, 0, 0, 0);
        fire("R8",  12'h160, 0, 32'h0000_0000, 32'h1000_0400, 0, 0, 0, 0);
        fire("R5",  12'h180, 0, 32'h4000_8000, 32'h2000_0000, 0, 0, 0, 0);
        // R7 reset class with FPU-disable set and low mask
        fire("R7",  12'h020, 0, 32'h0000_8030, 32'h3000_0000, 0, 0, 0, 0);
        fire("R7",  12'h140, 0, 32'h0000_8020, 32'h3000_0010, 0, 0, 0, 0);
        // R6 delay slot, and trap inside a delay slot
        fire("R6",  12'h0A0, 0, 32'h0000_0000, 32'h4000_0100, 1, 0, 0, 0);
        fire("R6",  12'h160, 0, 32'h0000_0000, 32'h4000_0200, 1, 0, 0, 0);
        // R2 blocked: rewrite to reset, and the kept code
        fire("R2",  12'h0E0, 0, 32'h1000_8000, 32'h5000_0000, 0, 0, 0, 0);
        fire("R2",  12'h1E0, 0, 32'h1000_0000, 32'h5000_0010, 0, 0, 0, 0);
        fire("R2",  12'h160, 0, 32'h1000_0000, 32'h5000_0020, 1, 0, 0, 0);
        // R9 interrupt
        fire("R9",  12'hFFF, 1, 32'h0000_0050, 32'h6000_0000, 0, 0, 1, 12'h3A0);
        // R4 no vector
        fire("R4",  12'hFFF, 1, 32'h0000_00A0, 32'h6000_0010, 0, 0, 0, 12'h3C0);
        // R3 blocked interrupt, without and with halt
        fire("R3",  12'hFFF, 1, 32'h1000_0000, 32'h7000_0000, 0, 0, 1, 12'h400);
        fire("R3",  12'hFFF, 1, 32'h1000_0000, 32'h7000_0010, 0, 1, 1, 12'h420);
        // R1 exception and interrupt together, also while blocked
        fire("R1",  12'h100, 1, 32'h0000_0000, 32'h8000_0000, 0, 0, 1, 12'h440);
        fire("R1",  12'h100, 1, 32'h1000_0000, 32'h8000_0010, 0, 1, 1, 12'h460);
        fire("R1",  12'h160, 1, 32'h0000_0000, 32'h8000_0020, 1, 0, 1, 12'h480);
        // R10 back-to-back then idle with request but no eval
        @(negedge clk);
        req_now = "R10";
        eval = 1; exc_code = 12'h0E0; sr_in = 0; pc_in = 32'h9000_0000;
        @(negedge clk);
        exc_code = 12'h040; pc_in = 32'h9000_0004;
        @(negedge clk);
        eval = 0; exc_code = 12'hFFF; irq_req = 1; vec_valid = 1;
        repeat (4) @(negedge clk);
        irq_req = 0;
        repeat (2) @(negedge clk);
        summary();
    end
endmodule